// File: doc/BRIEF.md
# Control Word Latch with Shared Serial/Parallel Loading

This block is the control-word front end of a tone encoder/decoder. It holds an eight-bit control word. Six bits are general data. One bit selects receive or transmit, and one bit enables the tone. The held word drives the rest of the chip. All pins are asynchronous to the system clock. They pass through a synchronizer before any decision is taken.

The word can be loaded in two ways. In parallel mode the six data pins and the two mode pins are copied into the holding register for as long as the load strobe is high. When the strobe falls, the last copied value stays. Serial mode is selected by a fixed static code on the two highest data pins. In this mode the next two data pins become a data line and a clock line. The host shifts in eight bits and then commits them with one high pulse on the load strobe. All inputs idle high, which matches external pull-ups.

Top module: `ctl_word_latch`

## Requirements
- R1: After reset the held word reads all ones (data outputs 6'b111111, rxtx_o = 1, tone_en_o = 1) and stays so while the load strobe is low.
- R2: While the synchronized load strobe is low, the outputs do not change, whatever the other pins do.
- R3: In parallel mode, while the load strobe is high, the outputs follow {dat_pin_i, rxtx_pin_i, tone_pin_i}. After the strobe falls, the value last copied is kept.
- R4: Serial mode is selected exactly when dat_pin_i[5] = 1 and dat_pin_i[4] = 0. Every other combination of those two pins gives parallel mode.
- R5: In serial mode, dat_pin_i[3] is the serial data and dat_pin_i[2] is the serial clock. One bit is taken on each rising edge of the serial clock.
- R6: Serial bit order: the first bit lands in ctl_data_o[5], then ctl_data_o[4] down to ctl_data_o[0], then rxtx_o, and the eighth bit lands in tone_en_o.
- R7: In serial mode, a low-high-low pulse on the load strobe moves the shifted word to the outputs. Shifting alone does not change the outputs.
- R8: When more than eight serial clocks arrive before the strobe, only the last eight bits are committed.
- R9: In serial mode, the rxtx, tone and low data pins have no effect. In parallel mode, toggling dat_pin_i[2] does not shift the serial register.
- R10: With the strobe held high in parallel mode, a pin change reaches the outputs on the third rising clock edge after it is applied, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_pin_i | input | 1 | Load strobe: transparent when high, holds when low |
| dat_pin_i | input | 6 | Data pins; bits 5/4 select the mode, bits 3/2 carry serial data and clock in serial mode |
| rxtx_pin_i | input | 1 | Receive/transmit select, parallel mode only |
| tone_pin_i | input | 1 | Tone enable, parallel mode only |
| ctl_data_o | output | 6 | Held data bits |
| rxtx_o | output | 1 | Held receive/transmit select |
| tone_en_o | output | 1 | Held tone enable |

## Verification
A corrupted shift register is invisible until the next strobe commits it. The word on the outputs then differs from the one shifted in, so every serial sweep step ends with a strobe and a compare. A wrong mode decode or a wrong hold condition shows as an output change within three clock edges of the strobe or pin edge that caused it. The bench therefore samples a few cycles after each stimulus, and it checks the exact edge at which a change appears for the latency requirement.

// File: rtl/ctl_latch_pkg.sv
package ctl_latch_pkg;

    localparam int unsigned DFLT_DATA_W  = 6;
    localparam int unsigned DFLT_SYNC_ST = 2;

    typedef enum logic {
        MODE_PAR = 1'b0,
        MODE_SER = 1'b1
    } lmode_e;

endpackage

// File: rtl/cl_sync.sv
module cl_sync #(
    parameter int unsigned W       = 1,
    parameter int unsigned STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    typedef struct packed {
        logic [STAGES-1:0][W-1:0] stg;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d.stg[0] = async_i;
        for (int i = 1; i < int'(STAGES); i++) begin
            st_d.stg[i] = st_q.stg[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.stg <= {STAGES{RST_VAL}};
        end else begin
            st_q <= st_d;
        end
    end

    assign sync_o = st_q.stg[STAGES-1];

endmodule

// File: rtl/cl_ser_shift.sv
module cl_ser_shift #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_i,
    input  logic         sclk_i,
    input  logic         sdi_i,
    output logic [W-1:0] word_o
);

    typedef struct packed {
        logic         clk_prev;
        logic [W-1:0] sh;
    } shift_st_t;

    shift_st_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.clk_prev = sclk_i;
        if (en_i && sclk_i && !st_q.clk_prev) begin
            st_d.sh = {st_q.sh[W-2:0], sdi_i};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.clk_prev <= 1'b1;
            st_q.sh       <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign word_o = st_q.sh;

endmodule

// File: rtl/cl_word_hold.sv
module cl_word_hold
    import ctl_latch_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld_i,
    input  lmode_e       mode_i,
    input  logic [W-1:0] par_i,
    input  logic [W-1:0] ser_i,
    output logic [W-1:0] word_o
);

    typedef struct packed {
        logic [W-1:0] word;
    } hold_st_t;

    hold_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ld_i) begin
            st_d.word = (mode_i == MODE_SER) ? ser_i : par_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.word <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign word_o = st_q.word;

endmodule

// File: rtl/ctl_word_latch.sv
module ctl_word_latch
    import ctl_latch_pkg::*;
#(
    parameter int unsigned DATA_W  = DFLT_DATA_W,
    parameter int unsigned SYNC_ST = DFLT_SYNC_ST
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_pin_i,
    input  logic [DATA_W-1:0] dat_pin_i,
    input  logic              rxtx_pin_i,
    input  logic              tone_pin_i,
    output logic [DATA_W-1:0] ctl_data_o,
    output logic              rxtx_o,
    output logic              tone_en_o
);

    localparam int unsigned WORD_W   = DATA_W + 2;
    localparam int unsigned PIN_W    = DATA_W + 3;
    localparam int unsigned SEL_HI   = DATA_W - 1;
    localparam int unsigned SEL_LO   = DATA_W - 2;
    localparam int unsigned SDI_BIT  = DATA_W - 3;
    localparam int unsigned SCLK_BIT = DATA_W - 4;

    logic [PIN_W-1:0]  pins_s;
    logic              ld_s;
    logic [DATA_W-1:0] dat_s;
    logic              rxtx_s;
    logic              tone_s;
    logic              ser_mode;
    lmode_e            mode;
    logic              sclk_s;
    logic              sdi_s;
    logic [WORD_W-1:0] par_word;
    logic [WORD_W-1:0] ser_word;
    logic [WORD_W-1:0] held_word;

    cl_sync #(
        .W       (PIN_W),
        .STAGES  (SYNC_ST),
        .RST_VAL ({PIN_W{1'b1}})
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({ld_pin_i, dat_pin_i, rxtx_pin_i, tone_pin_i}),
        .sync_o  (pins_s)
    );

    assign {ld_s, dat_s, rxtx_s, tone_s} = pins_s;

    assign ser_mode = dat_s[SEL_HI] & ~dat_s[SEL_LO];
    assign mode     = ser_mode ? MODE_SER : MODE_PAR;
    assign sclk_s   = dat_s[SCLK_BIT];
    assign sdi_s    = dat_s[SDI_BIT];
    assign par_word = {dat_s, rxtx_s, tone_s};

    cl_ser_shift #(
        .W (WORD_W)
    ) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (ser_mode),
        .sclk_i (sclk_s),
        .sdi_i  (sdi_s),
        .word_o (ser_word)
    );

    cl_word_hold #(
        .W (WORD_W)
    ) u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld_i   (ld_s),
        .mode_i (mode),
        .par_i  (par_word),
        .ser_i  (ser_word),
        .word_o (held_word)
    );

    assign {ctl_data_o, rxtx_o, tone_en_o} = held_word;

endmodule

// File: rtl/cl_latch_chk.sv
module cl_latch_chk #(
    parameter int unsigned W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         ld_s,
    input logic         ser_mode,
    input logic         sclk_s,
    input logic         sdi_s,
    input logic [W-1:0] par_word,
    input logic [W-1:0] ser_word,
    input logic [W-1:0] held_word
);

    AST_HOLD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_s |=> $stable(held_word)); // R2

    AST_PAR_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_s && !ser_mode) |=> held_word == $past(par_word)); // R3

    AST_SER_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_s && ser_mode) |=> held_word == $past(ser_word)); // R7

    AST_SHIFT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_mode && $rose(sclk_s)) |=>
            ser_word == {$past(ser_word[W-2:0]), $past(sdi_s)}); // R5

    AST_SHIFT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !ser_mode |=> $stable(ser_word)); // R9

endmodule

bind ctl_word_latch cl_latch_chk #(
    .W (WORD_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld_s      (ld_s),
    .ser_mode  (ser_mode),
    .sclk_s    (sclk_s),
    .sdi_s     (sdi_s),
    .par_word  (par_word),
    .ser_word  (ser_word),
    .held_word (held_word)
);

// File: tb/sim_ctl_word_latch.sv
`timescale 1ns/1ps
module sim_ctl_word_latch;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ld = 1'b0;
    logic [5:0] dat = 6'h00;
    logic       rxtx = 1'b0;
    logic       tone = 1'b0;
    logic [5:0] q_dat;
    logic       q_rxtx;
    logic       q_tone;
    int         n_run = 0;
    int         n_fail = 0;
    logic [7:0] last;

    always #5 clk = ~clk;

    ctl_word_latch u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .ld_pin_i   (ld),
        .dat_pin_i  (dat),
        .rxtx_pin_i (rxtx),
        .tone_pin_i (tone),
        .ctl_data_o (q_dat),
        .rxtx_o     (q_rxtx),
        .tone_en_o  (q_tone)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [7:0] exp);
        logic [7:0] act;
        act = {q_dat, q_rxtx, q_tone};
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic drive_par(input logic [7:0] w);
        {dat, rxtx, tone} = w;
    endtask

    task automatic enter_ser();
        dat[5] = 1'b1; dat[4] = 1'b0; dat[2] = 1'b0;
        tick(4);
    endtask

    task automatic shift_bits(input logic [15:0] bits, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            dat[3] = bits[i];
            dat[2] = 1'b0;
            tick(3);
            dat[2] = 1'b1;
            tick(3);
        end
        dat[2] = 1'b0;
        tick(3);
    endtask

    task automatic strobe();
        ld = 1'b1; tick(4);
        ld = 1'b0; tick(4);
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(4);
        check("R1 reset value", 8'hFF);

        // R3 / R4 / R2: sweep every parallel-mode code
        last = 8'hFF;
        for (int v = 0; v < 256; v++) begin
            logic [7:0] w;
            w = 8'(v);
            if (w[7] && !w[6]) continue;
            drive_par(w);
            tick(4);
            check("R2 pins change with strobe low", last);
            strobe();
            check("R3/R4 parallel load", w);
            last = w;
        end

        // R10: exact latency with strobe held high
        drive_par(8'h3C); ld = 1'b1; tick(5);
        check("R10 settle", 8'h3C);
        drive_par(8'h13);
        tick(2);
        check("R10 not before third edge", 8'h3C);
        tick(1);
        check("R10 on third edge", 8'h13);
        ld = 1'b0; tick(4);
        last = 8'h13;

        // R5 / R6 / R7 / R9: sweep every word through the serial port
        for (int v = 0; v < 256; v++) begin
            logic [7:0] w;
            w = 8'(v);
            enter_ser();
            rxtx = ~w[1]; tone = ~w[0]; dat[1:0] = ~w[3:2];
            shift_bits({8'h00, w}, 8);
            check("R7 no commit before strobe", last);
            strobe();
            check("R5/R6/R9 serial word", w);
            last = w;
        end

        // R8: eleven clocks, last eight kept
        enter_ser();
        shift_bits(16'h05A6, 11);
        strobe();
        check("R8 overrun keeps last eight", 8'hA6);

        // R9: D2 activity in parallel mode must not shift
        dat = 6'b000000; tick(4);
        for (int i = 0; i < 8; i++) begin
            dat[3] = i[0];
            dat[2] = 1'b1; tick(3);
            dat[2] = 1'b0; tick(3);
        end
        check("R9 parallel toggles leave outputs", 8'hA6);
        enter_ser();
        strobe();
        check("R9 serial register untouched in parallel mode", 8'hA6);

        // R4: code 11 on the select pins is parallel
        drive_par(8'hC5); tick(4);
        strobe();
        check("R4 select 11 is parallel", 8'hC5);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #1_500_000;
        n_run++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule